// File: doc/BRIEF.md
# Parallel Flash Bank Query Response Formatter

This block forms the read data returned by a flash bank while the bank sits in one of its two query modes: the identifier mode, which reports the manufacturer and device codes, and the common flash interface mode, which reads a fixed table of parameter bytes. The bank is built from several identical devices wired side by side, so the block has to turn a bus byte offset into a per-device query index, fetch the byte or code one device would return, and copy it into every device lane of the bank. A bus access wider than the bank is built from several bank-wide answers placed in consecutive slices. Command decoding and the array itself sit elsewhere; this block only shapes query data.

The bank shape is fixed by three parameters: bank width, device width and the widest mode the devices support. A narrow use of a wide part (byte mode of a 16-bit device) shifts the query addresses and repeats table bytes instead of zero-padding them. A small two-state machine registers each answer: state IDLE waits; a read strobe takes transition ACCEPT into state SERVE, where the response is valid; a further strobe in SERVE takes transition CHAIN and stays in SERVE with fresh data; SERVE without a strobe takes transition RETIRE back to IDLE.

Top module: `cfiq_formatter`

## Requirements
- R1: While reset is asserted and after it is released, and until the first strobe, `rsp_valid` is 0 and `rsp_data` is zero.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle with `rd_stb` high, and `rsp_data` keeps its value in any cycle that follows a cycle without a strobe.
- R3: Each query index is the bus offset shifted right by log2(bank width) + log2(maximum device width) − log2(device width).
- R4: The parameter table gives "QRY" (0x51, 0x52, 0x59) at indices 0x10 to 0x12, 0x01 at 0x13, "PRI" (0x50, 0x52, 0x49) at 0x31 to 0x33, a write-buffer size exponent at 0x2A of 8 for a one-byte bank and 11 otherwise, 0x01 at 0x2C for one uniform erase region, the log2 of one device's size at 0x27, the block count minus one (low then high byte) at 0x2D/0x2E and bytes 1 and 2 of one device's sector length at 0x2F/0x30; the remaining entries below 0x52 are the fixed constants of the table or zero.
- R5: In table mode an index of 0x52 or above yields zero for that device.
- R6: With a device width below the maximum device width, a byte-wide device repeats its table byte in every byte of its maximum width; any other narrower-than-maximum shape returns zero in table mode.
- R7: The answer of one device, taken as its low device-width bytes, is copied into every device-width lane of the bank.
- R8: In identifier mode the low 8 bits of the index choose the answer: 0 gives the manufacturer code, 1 gives the device code, every other value gives zero.
- R9: For an access wider than the bank, slice j (bytes j×bank width upward) holds the answer for offset + j×bank width, the sum wrapping at the address width.
- R10: `acc_size` 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes; bytes at or above the access width read zero, and an access narrower than the bank returns the low bytes of the bank answer.
- R11: `qmode` 0 selects identifier mode and 1 selects table mode, sampled together with the offset on the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read strobe; other inputs are sampled with it |
| qmode | input | 1 | 0 identifier mode, 1 table mode |
| offset | input | ADDR_W | Bus byte offset of the access |
| acc_size | input | 2 | Access width code: 0 byte, 1 two bytes, 2 or 3 four bytes |
| rsp_data | output | 32 | Formatted response, registered |
| rsp_valid | output | 1 | High the cycle after a strobe |

## Verification
The hardest situations to reach from the ports are the joined accesses where consecutive slices straddle a change of index, the end of the table at 0x52, or the wrap of the offset at the top of the address space, because each slice scales its own offset and only a few offsets put slice boundaries there. The stimulus sweeps every offset across the whole table with all access sizes, and also drives offsets just below the top of the address space and an identifier sweep past the 256-entry wrap of the low index byte. Several bank shapes, including the unsupported narrow shape, receive the same stimulus and are each compared every cycle against a behavioural model.

// File: rtl/cfiq_pkg.sv
package cfiq_pkg;

    localparam int BUS_BYTES   = 4;
    localparam int TBL_ENTRIES = 'h52;

    typedef enum logic {
        QM_IDENT = 1'b0,
        QM_QUERY = 1'b1
    } qmode_e;

    typedef enum logic [1:0] {
        AS_BYTE  = 2'd0,
        AS_HALF  = 2'd1,
        AS_WORD  = 2'd2,
        AS_WORD2 = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } fsm_state_e;

    // Number of bus bytes covered by an access code.
    function automatic logic [2:0] size_to_bytes(input acc_size_e s);
        logic [2:0] n;
        unique case (s)
            AS_BYTE:  n = 3'd1;
            AS_HALF:  n = 3'd2;
            AS_WORD:  n = 3'd4;
            AS_WORD2: n = 3'd4;
        endcase
        return n;
    endfunction

    // One entry of the per-device parameter table.
    function automatic logic [7:0] table_entry(
        input logic [7:0] idx,
        input int         bank_bytes,
        input int         size_exp,
        input int         blocks,
        input int         sect_per_dev
    );
        logic [7:0] v;
        v = 8'h00;
        case (idx)
            8'h31: v = 8'h50;
            8'h32: v = 8'h52;
            8'h33: v = 8'h49;
            8'h34: v = 8'h31;
            8'h35: v = 8'h30;
            8'h3F: v = 8'h01;
            8'h10: v = 8'h51;
            8'h11: v = 8'h52;
            8'h12: v = 8'h59;
            8'h13: v = 8'h01;
            8'h15: v = 8'h31;
            8'h1B: v = 8'h45;
            8'h1C: v = 8'h55;
            8'h1F: v = 8'h07;
            8'h20: v = 8'h07;
            8'h21: v = 8'h0A;
            8'h23: v = 8'h04;
            8'h24: v = 8'h04;
            8'h25: v = 8'h04;
            8'h28: v = 8'h02;
            8'h2C: v = 8'h01;
            8'h27: v = 8'(size_exp);
            8'h2A: v = (bank_bytes == 1) ? 8'h08 : 8'h0B;
            8'h2D: v = 8'(blocks - 1);
            8'h2E: v = 8'((blocks - 1) >> 8);
            8'h2F: v = 8'(sect_per_dev >> 8);
            8'h30: v = 8'(sect_per_dev >> 16);
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfiq_devresp.sv
module cfiq_devresp
    import cfiq_pkg::*;
#(
    parameter int          BANK_BYTES    = 4,
    parameter int          DEV_BYTES     = 1,
    parameter int          MAX_DEV_BYTES = 2,
    parameter int          ADDR_W        = 16,
    parameter int          SIZE_EXP      = 22,
    parameter int          BLOCKS        = 64,
    parameter int          SECT_PER_DEV  = 65536,
    parameter logic [15:0] MFR_CODE      = 16'h0089,
    parameter logic [15:0] PART_CODE     = 16'h0018
) (
    input  logic                   mode,
    input  logic [ADDR_W-1:0]      index,
    output logic [DEV_BYTES*8-1:0] dev_word
);

    localparam int DW = DEV_BYTES * 8;

    logic [7:0]  tbl_byte;
    logic [31:0] tbl_hold;
    logic [31:0] id_hold;

    // Table byte, zero past the end of the table.
    always_comb begin
        if (index < ADDR_W'(TBL_ENTRIES))
            tbl_byte = table_entry(index[7:0], BANK_BYTES, SIZE_EXP, BLOCKS, SECT_PER_DEV);
        else
            tbl_byte = 8'h00;
    end

    // Per-device widening chosen by the bank shape.
    generate
        if (DEV_BYTES == MAX_DEV_BYTES) begin : g_native
            always_comb tbl_hold = {24'h0, tbl_byte};
        end else if (DEV_BYTES == 1) begin : g_byte_mode
            always_comb begin
                for (int m = 0; m < BUS_BYTES; m++)
                    tbl_hold[m*8 +: 8] = (m < MAX_DEV_BYTES) ? tbl_byte : 8'h00;
            end
        end else begin : g_unsupported
            always_comb tbl_hold = 32'h0;
        end
    endgenerate

    always_comb begin
        unique case (index[7:0])
            8'h00:   id_hold = {16'h0, MFR_CODE};
            8'h01:   id_hold = {16'h0, PART_CODE};
            default: id_hold = 32'h0;
        endcase
    end

    always_comb begin
        if (qmode_e'(mode) == QM_QUERY)
            dev_word = tbl_hold[DW-1:0];
        else
            dev_word = id_hold[DW-1:0];
    end

endmodule

// File: rtl/cfiq_lanefan.sv
module cfiq_lanefan #(
    parameter int BANK_BYTES = 4,
    parameter int DEV_BYTES  = 1
) (
    input  logic [DEV_BYTES*8-1:0]  dev_word,
    output logic [BANK_BYTES*8-1:0] bank_word
);

    localparam int LANES = BANK_BYTES / DEV_BYTES;
    localparam int DW    = DEV_BYTES * 8;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign bank_word[k*DW +: DW] = dev_word;
        end
    endgenerate

endmodule

// File: rtl/cfiq_ctrl.sv
module cfiq_ctrl
    import cfiq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    input  logic [31:0] next_data,
    output logic [31:0] rsp_data,
    output logic        rsp_valid
);

    fsm_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT (IDLE->SERVE), CHAIN (SERVE->SERVE), RETIRE (SERVE->IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_stb) state_d = ST_SERVE;
            ST_SERVE: state_d = rd_stb ? ST_SERVE : ST_IDLE;
        endcase
    end

    // Data register, loaded only on a strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_data <= 32'h0;
        else if (rd_stb) rsp_data <= next_data;
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  rsp_valid = 1'b0;
            ST_SERVE: rsp_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfiq_formatter.sv
module cfiq_formatter
    import cfiq_pkg::*;
#(
    parameter int          BANK_BYTES    = 4,
    parameter int          DEV_BYTES     = 1,
    parameter int          MAX_DEV_BYTES = 2,
    parameter int          ADDR_W        = 16,
    parameter int          SECTOR_BYTES  = 262144,
    parameter int          NUM_BLOCKS    = 64,
    parameter logic [15:0] MFR_CODE      = 16'h0089,
    parameter logic [15:0] PART_CODE     = 16'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              qmode,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        acc_size,
    output logic [31:0]       rsp_data,
    output logic              rsp_valid
);

    localparam int NUM_DEVS     = BANK_BYTES / DEV_BYTES;
    localparam int SECT_PER_DEV = SECTOR_BYTES / NUM_DEVS;
    localparam int SIZE_EXP     = $clog2(SECT_PER_DEV * NUM_BLOCKS);
    localparam int IDX_SHIFT    = $clog2(BANK_BYTES) + $clog2(MAX_DEV_BYTES) - $clog2(DEV_BYTES);
    localparam int NUM_SLOTS    = BUS_BYTES / BANK_BYTES;
    localparam int BW           = BANK_BYTES * 8;

    logic [NUM_SLOTS*BW-1:0] joined;
    logic [31:0]             masked;
    logic [2:0]              nbytes;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic [ADDR_W-1:0]      slot_off;
            logic [ADDR_W-1:0]      slot_idx;
            logic [DEV_BYTES*8-1:0] slot_dev;
            logic [BW-1:0]          slot_bank;

            assign slot_off = offset + ADDR_W'(s * BANK_BYTES);
            assign slot_idx = slot_off >> IDX_SHIFT;

            cfiq_devresp #(
                .BANK_BYTES   (BANK_BYTES),
                .DEV_BYTES    (DEV_BYTES),
                .MAX_DEV_BYTES(MAX_DEV_BYTES),
                .ADDR_W       (ADDR_W),
                .SIZE_EXP     (SIZE_EXP),
                .BLOCKS       (NUM_BLOCKS),
                .SECT_PER_DEV (SECT_PER_DEV),
                .MFR_CODE     (MFR_CODE),
                .PART_CODE    (PART_CODE)
            ) u_dev (
                .mode    (qmode),
                .index   (slot_idx),
                .dev_word(slot_dev)
            );

            cfiq_lanefan #(
                .BANK_BYTES(BANK_BYTES),
                .DEV_BYTES (DEV_BYTES)
            ) u_fan (
                .dev_word (slot_dev),
                .bank_word(slot_bank)
            );

            assign joined[s*BW +: BW] = slot_bank;
        end
    endgenerate

    assign nbytes = size_to_bytes(acc_size_e'(acc_size));

    // Keep only the bytes inside the access width.
    always_comb begin
        for (int b = 0; b < BUS_BYTES; b++)
            masked[b*8 +: 8] = (3'(b) < nbytes) ? joined[b*8 +: 8] : 8'h00;
    end

    cfiq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .next_data(masked),
        .rsp_data (rsp_data),
        .rsp_valid(rsp_valid)
    );

endmodule

// File: rtl/cfiq_formatter_chk.sv
module cfiq_formatter_chk #(
    parameter int BANK_BYTES    = 4,
    parameter int DEV_BYTES     = 1,
    parameter int MAX_DEV_BYTES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_stb,
    input logic        qmode,
    input logic [1:0]  acc_size,
    input logic [31:0] rsp_data,
    input logic        rsp_valid
);

    localparam int  LANES = BANK_BYTES / DEV_BYTES;
    localparam int  DW    = DEV_BYTES * 8;
    localparam bit  UNSUP = (DEV_BYTES < MAX_DEV_BYTES) && (DEV_BYTES != 1);

    logic [2:0] cap_bytes;
    logic       cap_query;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_bytes <= 3'd4;
            cap_query <= 1'b0;
        end else if (rd_stb) begin
            cap_bytes <= (acc_size == 2'd0) ? 3'd1 : (acc_size == 2'd1) ? 3'd2 : 3'd4;
            cap_query <= qmode;
        end
    end

    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

    // R2
    a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rsp_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rsp_valid);
    a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rsp_data));

    // R10
    a_r10_upper_bytes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_bytes < 3'd4) |-> ((rsp_data >> {cap_bytes, 3'b000}) == 32'h0));

    // R6
    a_r6_unsupported_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_query && UNSUP) |-> (rsp_data == 32'h0));

    // R7
    generate
        for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
            a_r7_lane_copy: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid && cap_bytes >= 3'(BANK_BYTES)) |->
                (rsp_data[k*DW +: DW] == rsp_data[DW-1:0]));
        end
    endgenerate

endmodule

bind cfiq_formatter cfiq_formatter_chk #(
    .BANK_BYTES   (BANK_BYTES),
    .DEV_BYTES    (DEV_BYTES),
    .MAX_DEV_BYTES(MAX_DEV_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .qmode    (qmode),
    .acc_size (acc_size),
    .rsp_data (rsp_data),
    .rsp_valid(rsp_valid)
);

// File: tb/cfiq_formatter_test.sv
`timescale 1ns/1ps
module cfiq_formatter_test;

    localparam int          SECT  = 262144;
    localparam int          NBLK  = 64;
    localparam logic [15:0] MFR   = 16'h0089;
    localparam logic [15:0] PART  = 16'h0018;
    localparam int          NINST = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        qmode = 1'b0;
    logic [15:0] offset = 16'h0;
    logic [1:0]  acc_size = 2'd0;

    logic [31:0] d0, d1, d2, d3, d4;
    logic        v0, v1, v2, v3, v4;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] held [NINST];
    logic        p_stb = 1'b0;
    logic        p_mode = 1'b0;
    logic [15:0] p_off = 16'h0;
    logic [1:0]  p_acc = 2'd0;

    always #4 clk = ~clk;

    // Default shape: 4-byte bank of byte-mode 16-bit parts.
    cfiq_formatter #(.BANK_BYTES(4), .DEV_BYTES(1), .MAX_DEV_BYTES(2), .ADDR_W(16),
        .SECTOR_BYTES(SECT), .NUM_BLOCKS(NBLK), .MFR_CODE(MFR), .PART_CODE(PART)) uut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .qmode(qmode), .offset(offset),
        .acc_size(acc_size), .rsp_data(d0), .rsp_valid(v0));
    cfiq_formatter #(.BANK_BYTES(1), .DEV_BYTES(1), .MAX_DEV_BYTES(1), .ADDR_W(16),
        .SECTOR_BYTES(SECT), .NUM_BLOCKS(NBLK), .MFR_CODE(MFR), .PART_CODE(PART)) u_b1 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .qmode(qmode), .offset(offset),
        .acc_size(acc_size), .rsp_data(d1), .rsp_valid(v1));
    cfiq_formatter #(.BANK_BYTES(2), .DEV_BYTES(2), .MAX_DEV_BYTES(2), .ADDR_W(16),
        .SECTOR_BYTES(SECT), .NUM_BLOCKS(NBLK), .MFR_CODE(MFR), .PART_CODE(PART)) u_b2 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .qmode(qmode), .offset(offset),
        .acc_size(acc_size), .rsp_data(d2), .rsp_valid(v2));
    cfiq_formatter #(.BANK_BYTES(4), .DEV_BYTES(2), .MAX_DEV_BYTES(2), .ADDR_W(16),
        .SECTOR_BYTES(SECT), .NUM_BLOCKS(NBLK), .MFR_CODE(MFR), .PART_CODE(PART)) u_b4d2 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .qmode(qmode), .offset(offset),
        .acc_size(acc_size), .rsp_data(d3), .rsp_valid(v3));
    cfiq_formatter #(.BANK_BYTES(4), .DEV_BYTES(2), .MAX_DEV_BYTES(4), .ADDR_W(16),
        .SECTOR_BYTES(SECT), .NUM_BLOCKS(NBLK), .MFR_CODE(MFR), .PART_CODE(PART)) u_bad (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .qmode(qmode), .offset(offset),
        .acc_size(acc_size), .rsp_data(d4), .rsp_valid(v4));

    function automatic int lg2(int x);
        int e = 0;
        while ((1 << e) < x) e++;
        return e;
    endfunction

    // Behavioural parameter table (R4).
    function automatic int ref_tbl(int idx, int bank, int dev);
        int spd = SECT / (bank / dev);
        if (idx == 'h10) return 'h51;
        if (idx == 'h11) return 'h52;
        if (idx == 'h12) return 'h59;
        if (idx == 'h13) return 'h01;
        if (idx == 'h15) return 'h31;
        if (idx == 'h1B) return 'h45;
        if (idx == 'h1C) return 'h55;
        if (idx == 'h1F || idx == 'h20) return 'h07;
        if (idx == 'h21) return 'h0A;
        if (idx >= 'h23 && idx <= 'h25) return 'h04;
        if (idx == 'h27) return lg2(spd * NBLK);
        if (idx == 'h28) return 'h02;
        if (idx == 'h2A) return (bank == 1) ? 8 : 11;
        if (idx == 'h2C) return 'h01;
        if (idx == 'h2D) return (NBLK - 1) & 255;
        if (idx == 'h2E) return ((NBLK - 1) >> 8) & 255;
        if (idx == 'h2F) return (spd >> 8) & 255;
        if (idx == 'h30) return (spd >> 16) & 255;
        if (idx == 'h31) return 'h50;
        if (idx == 'h32) return 'h52;
        if (idx == 'h33) return 'h49;
        if (idx == 'h34) return 'h31;
        if (idx == 'h35) return 'h30;
        if (idx == 'h3F) return 'h01;
        return 0;
    endfunction

    // One device's answer, low dev bytes (R5, R6, R8).
    function automatic longint ref_dev(bit mode, int idx, int dev, int maxd);
        longint v;
        if (mode) begin
            if (idx >= 'h52) return 0;
            if (dev != maxd && dev != 1) return 0;
            return longint'(ref_tbl(idx, 0, 0) == 0 ? 0 : 0);
        end
        v = ((idx & 255) == 0) ? longint'(MFR) : ((idx & 255) == 1) ? longint'(PART) : 0;
        return v & ((longint'(1) << (8 * dev)) - 1);
    endfunction

    function automatic logic [31:0] ref_out(bit mode, int off, int acc, int bank, int dev, int maxd);
        longint out = 0;
        int ab = (acc == 0) ? 1 : (acc == 1) ? 2 : 4;
        int sh = lg2(bank) + lg2(maxd) - lg2(dev);
        for (int j = 0; j * bank < 4; j++) begin
            int o = (off + j * bank) & 16'hFFFF;
            int ix = o >> sh;
            longint dv;
            if (mode)
                dv = (ix >= 'h52 || (dev != maxd && dev != 1)) ? 0 : longint'(ref_tbl(ix, bank, dev));
            else
                dv = ref_dev(mode, ix, dev, maxd);
            for (int k = 0; k < bank / dev; k++)
                out |= dv << (8 * (j * bank + k * dev));
        end
        out &= (longint'(1) << (8 * ab)) - 1;
        return 32'(out);
    endfunction

    task automatic cmp(int id, int bank, int dev, int maxd, logic v, logic [31:0] d,
                       string tag, string itag);
        logic [31:0] ed;
        ed = p_stb ? ref_out(p_mode, int'(p_off), int'(p_acc), bank, dev, maxd) : held[id];
        held[id] = ed;
        n_vec++;
        if (v !== p_stb || d !== ed) begin
            n_bad++;
            $display("FAIL %s/%s inst%0d off=%h mode=%0d acc=%0d: got v=%b d=%h exp v=%b d=%h",
                     tag, itag, id, p_off, p_mode, p_acc, v, d, p_stb, ed);
        end
    endtask

    // uut covers R3 scaling, u_b1 R11 mode select at unit shift, u_b4d2 R7 lanes, u_bad R6.
    task automatic step(logic stb, logic mode, logic [15:0] off, logic [1:0] acc, string tag);
        @(negedge clk);
        cmp(0, 4, 1, 2, v0, d0, tag, "R3");
        cmp(1, 1, 1, 1, v1, d1, tag, "R11");
        cmp(2, 2, 2, 2, v2, d2, tag, "R9");
        cmp(3, 4, 2, 2, v3, d3, tag, "R7");
        cmp(4, 4, 2, 4, v4, d4, tag, "R6");
        p_stb = stb; p_mode = mode; p_off = off; p_acc = acc;
        rd_stb = stb; qmode = mode; offset = off; acc_size = acc;
    endtask

    initial begin
        for (int i = 0; i < NINST; i++) held[i] = 32'h0;
        // R1: reset state
        repeat (3) step(1'b0, 1'b0, 16'h0, 2'd0, "R1");
        rst_n = 1'b1;
        repeat (2) step(1'b0, 1'b0, 16'h0, 2'd0, "R1");
        // R4: table sweep, single bytes
        for (int o = 0; o < 'h300; o++) step(1'b1, 1'b1, 16'(o), 2'd0, "R4");
        // R9: joined full-width accesses
        for (int o = 0; o < 'h300; o++) step(1'b1, 1'b1, 16'(o), 2'd2, "R9");
        // R10: half-width and the alternate full-width code
        for (int o = 0; o < 'h300; o++) step(1'b1, 1'b1, 16'(o), 2'(1 + 2 * (o & 1)), "R10");
        // R8: identifier sweep past the low-byte wrap
        for (int o = 0; o < 'h2000; o += 3) step(1'b1, 1'b0, 16'(o), 2'(o % 3), "R8");
        // R5: table end and offset wrap at the top of the space
        for (int o = 'hFFE0; o <= 'hFFFF; o++) step(1'b1, 1'b1, 16'(o), 2'd2, "R5");
        // R2: strobes with gaps, mixed modes
        for (int k = 0; k < 120; k++)
            step(1'(k % 3 != 0), 1'(k % 2), 16'(k * 5), 2'(k % 4), "R2");
        step(1'b0, 1'b0, 16'h0, 2'd0, "R2");
        step(1'b0, 1'b0, 16'h0, 2'd0, "R2");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout exp finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule